// File: doc/BRIEF.md
# Serial Slave Pause-Mode Front End

This block sits at the pin side of a serial memory-style slave. It receives chip-select, serial clock, serial data in, an active-low pause (hold) input, an active-low write-protect input and a busy flag. All of these are oversampled in a fast system clock. The block detects serial clock edges and passes them on as one-cycle shift pulses to a downstream command shifter. It also drives the enable for the serial data output.

While the pause input is active and the slave is selected, the block freezes the serial transfer. Serial clock edges and data are dropped, and the output enable is withdrawn. Entry into and exit from the pause are aligned to the serial clock. A change seen while the clock is low takes effect at once. A change seen while the clock is high waits for the next falling edge.

Deselecting the slave while the pause input is still active aborts the transfer. The block then issues an abort pulse and clears the write-enable latch that it keeps for downstream logic. Write-protect and busy are forwarded unchanged whether or not the transfer is paused.

Top module: `spi_hold_gate`

## Requirements
- R1: After synchronous reset `so_oe`, `hold_active`, `shift_rise`, `shift_fall`, `abort_pulse` and `wel` are all 0.
- R2: Pause is entered only while `cs_n` and `hold_n` are both low. If the synchronized `sck` is low when the low `hold_n` is seen, `hold_active` rises at once. If `sck` is high, `hold_active` rises only when `sck` is next seen low. A `hold_n` release seen before that falling edge cancels the pending pause.
- R3: Pause is left when `hold_n` goes high. If `sck` is low, the exit takes effect at once. If `sck` is high, the exit waits until `sck` is next seen low, and `hold_active` stays 1 until then.
- R4: `so_oe` is 1 exactly when the slave is selected and not paused, including the wait before a pending pause begins. It is never 1 together with `hold_active`, and it is 0 while deselected.
- R5: A detected `sck` rise or fall is forwarded as a one-cycle `shift_rise`/`shift_fall` pulse only when the block is selected and not paused after that cycle's state update. The falling edge that starts a pause is dropped. The falling edge that ends one is forwarded.
- R6: `wp_n_o` and `busy_o` follow `wp_n` and `busy` at all times, paused or not.
- R7: When `cs_n` is seen high while the block is selected and `hold_n` is still low, `abort_pulse` is 1 for one cycle and `wel` is 0 in that same cycle. When `cs_n` is seen high with `hold_n` high, no abort pulse is issued.
- R8: `wel` is set to 1 by a one-cycle `wel_set` and cleared to 0 by `wel_clr`. `wel_clr` wins when both are high. Both take effect on the next clock edge.
- R9: Every pin input passes two synchronizer flops and one output register, so a change applied before clock edge k is visible on the outputs after edge k+2. `si_bit` carries the synchronized serial data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select pin, active low |
| sck | input | 1 | Serial clock pin |
| si | input | 1 | Serial data input pin |
| hold_n | input | 1 | Pause pin, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Self-timed operation in progress |
| wel_set | input | 1 | One-cycle set of the write-enable latch |
| wel_clr | input | 1 | One-cycle clear of the write-enable latch |
| shift_rise | output | 1 | Forwarded serial clock rising edge pulse |
| shift_fall | output | 1 | Forwarded serial clock falling edge pulse |
| si_bit | output | 1 | Synchronized serial data bit |
| so_oe | output | 1 | Output enable for serial data out |
| hold_active | output | 1 | Transfer is paused |
| abort_pulse | output | 1 | One-cycle abort of the current transfer |
| wel | output | 1 | Write-enable latch |
| wp_n_o | output | 1 | Synchronized write-protect |
| busy_o | output | 1 | Synchronized busy flag |

## Verification
The pause input is asserted in both serial clock phases. A low-phase assertion must pause at once, and a high-phase assertion must wait for the falling edge. The release is tested the same way, so a design that ignores the phase or snaps on the wrong edge is caught. A pause that is asserted and then released before the edge checks that a pending entry is cancelled. Deselecting during a pause is compared with deselecting during normal transfer, which shows whether the abort and the latch clear depend on the pause level. Write-protect and busy toggle during the pause to show that they are forwarded independently of it.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_ACTIVE    = 3'd1,
    ST_HOLD_PEND = 3'd2,
    ST_HOLD      = 3'd3,
    ST_REL_PEND  = 3'd4
  } hold_state_e;

  // bit positions inside the synchronized pin vector
  localparam int PIN_CS   = 5;
  localparam int PIN_SCK  = 4;
  localparam int PIN_SI   = 3;
  localparam int PIN_HOLD = 2;
  localparam int PIN_WP   = 1;
  localparam int PIN_BUSY = 0;
  localparam int PIN_W    = 6;
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= RST_VAL;
    else     pipe[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[g] <= RST_VAL;
      else     pipe[g] <= pipe[g-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge (
  input  logic clk,
  input  logic rst,
  input  logic sck_s,
  output logic rise,
  output logic fall
);
  logic sck_prev;

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b0;
    else     sck_prev <= sck_s;
  end

  assign rise = sck_s & ~sck_prev;
  assign fall = ~sck_s & sck_prev;
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
  import spi_hold_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cs_n_s,
  input  logic hold_n_s,
  input  logic sck_s,
  input  logic rise,
  input  logic fall,
  output logic so_oe,
  output logic hold_active,
  output logic shift_rise,
  output logic shift_fall,
  output logic abort_pulse,
  output logic abort_now
);
  hold_state_e state_q, state_d;
  logic pass_d, held_d;

  always_comb begin
    state_d   = state_q;
    abort_now = 1'b0;
    if (state_q != ST_IDLE && cs_n_s) begin
      state_d   = ST_IDLE;
      abort_now = ~hold_n_s;
    end else begin
      case (state_q)
        ST_IDLE:      if (!cs_n_s) state_d = ST_ACTIVE;
        ST_ACTIVE:    if (!hold_n_s) state_d = sck_s ? ST_HOLD_PEND : ST_HOLD;
        ST_HOLD_PEND: begin
          if (hold_n_s)    state_d = ST_ACTIVE;
          else if (!sck_s) state_d = ST_HOLD;
        end
        ST_HOLD:      if (hold_n_s) state_d = sck_s ? ST_REL_PEND : ST_ACTIVE;
        ST_REL_PEND: begin
          if (!hold_n_s)   state_d = ST_HOLD;
          else if (!sck_s) state_d = ST_ACTIVE;
        end
        default:      state_d = ST_IDLE;
      endcase
    end
  end

  assign pass_d = (state_d == ST_ACTIVE) || (state_d == ST_HOLD_PEND);
  assign held_d = (state_d == ST_HOLD) || (state_d == ST_REL_PEND);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      so_oe       <= 1'b0;
      hold_active <= 1'b0;
      shift_rise  <= 1'b0;
      shift_fall  <= 1'b0;
      abort_pulse <= 1'b0;
    end else begin
      state_q     <= state_d;
      so_oe       <= pass_d;
      hold_active <= held_d;
      shift_rise  <= rise & pass_d;
      shift_fall  <= fall & pass_d;
      abort_pulse <= abort_now;
    end
  end

  // R4
  oe_hold_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(so_oe && hold_active));

  // R5
  hold_blocks_shift_chk: assert property (@(posedge clk) disable iff (rst)
    hold_active |-> (!shift_rise && !shift_fall));

  // R2
  hold_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD && $past(state_q) != ST_HOLD && $past(state_q) != ST_REL_PEND)
    |-> $past(!cs_n_s && !hold_n_s && !sck_s));

  // R3
  hold_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACTIVE && ($past(state_q) == ST_HOLD || $past(state_q) == ST_REL_PEND))
    |-> $past(hold_n_s && !sck_s));
endmodule

// File: rtl/spi_hold_wel.sv
module spi_hold_wel (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic abort_i,
  output logic wel
);
  always_ff @(posedge clk) begin
    if (rst)                  wel <= 1'b0;
    else if (clr_i | abort_i) wel <= 1'b0;
    else if (set_i)           wel <= 1'b1;
  end

  // R8
  wel_clr_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !wel);

  // R8
  wel_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i && !abort_i) |=> wel);
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
  import spi_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  input  logic busy,
  input  logic wel_set,
  input  logic wel_clr,
  output logic shift_rise,
  output logic shift_fall,
  output logic si_bit,
  output logic so_oe,
  output logic hold_active,
  output logic abort_pulse,
  output logic wel,
  output logic wp_n_o,
  output logic busy_o
);
  localparam logic [PIN_W-1:0] PIN_RST = (1 << PIN_CS) | (1 << PIN_HOLD) | (1 << PIN_WP);

  logic [PIN_W-1:0] pins_raw, pins_s;
  logic rise, fall, abort_now;

  assign pins_raw[PIN_CS]   = cs_n;
  assign pins_raw[PIN_SCK]  = sck;
  assign pins_raw[PIN_SI]   = si;
  assign pins_raw[PIN_HOLD] = hold_n;
  assign pins_raw[PIN_WP]   = wp_n;
  assign pins_raw[PIN_BUSY] = busy;

  spi_hold_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst(rst), .d(pins_raw), .q(pins_s)
  );

  spi_hold_edge u_edge (
    .clk(clk), .rst(rst), .sck_s(pins_s[PIN_SCK]), .rise(rise), .fall(fall)
  );

  spi_hold_fsm u_fsm (
    .clk(clk), .rst(rst),
    .cs_n_s(pins_s[PIN_CS]), .hold_n_s(pins_s[PIN_HOLD]), .sck_s(pins_s[PIN_SCK]),
    .rise(rise), .fall(fall),
    .so_oe(so_oe), .hold_active(hold_active),
    .shift_rise(shift_rise), .shift_fall(shift_fall),
    .abort_pulse(abort_pulse), .abort_now(abort_now)
  );

  spi_hold_wel u_wel (
    .clk(clk), .rst(rst), .set_i(wel_set), .clr_i(wel_clr), .abort_i(abort_now), .wel(wel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      si_bit <= 1'b0;
      wp_n_o <= 1'b1;
      busy_o <= 1'b0;
    end else begin
      si_bit <= pins_s[PIN_SI];
      wp_n_o <= pins_s[PIN_WP];
      busy_o <= pins_s[PIN_BUSY];
    end
  end

  // R7
  abort_clears_wel_chk: assert property (@(posedge clk) disable iff (rst)
    abort_pulse |-> (!wel && !so_oe && !hold_active));
endmodule

// File: tb/spi_hold_gate_test.sv
module spi_hold_gate_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1, busy = 1'b0;
  logic wel_set = 1'b0, wel_clr = 1'b0;
  logic shift_rise, shift_fall, si_bit, so_oe, hold_active, abort_pulse, wel, wp_n_o, busy_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  bit sck_run = 0;
  int sck_cnt = 0;
  int abort_seen = 0;
  int shifts_in_hold = 0;

  always #4 clk = ~clk;

  spi_hold_gate uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .wp_n(wp_n), .busy(busy), .wel_set(wel_set), .wel_clr(wel_clr),
    .shift_rise(shift_rise), .shift_fall(shift_fall), .si_bit(si_bit), .so_oe(so_oe),
    .hold_active(hold_active), .abort_pulse(abort_pulse), .wel(wel),
    .wp_n_o(wp_n_o), .busy_o(busy_o)
  );

  // reference model: pin history as arrays, mode as an integer
  int mode = 0; // 0 idle, 1 run, 2 wait-to-pause, 3 paused, 4 wait-to-resume
  bit h1 [6];
  bit h2 [6];
  bit prev_clk_lvl;
  bit e_oe, e_hold, e_rise, e_fall, e_abort, e_wel, e_si, e_wp, e_busy;

  task automatic model_reset();
    h1 = '{1, 0, 0, 1, 1, 0};
    h2 = '{1, 0, 0, 1, 1, 0};
    prev_clk_lvl = 0; mode = 0;
    e_oe = 0; e_hold = 0; e_rise = 0; e_fall = 0; e_abort = 0; e_wel = 0;
    e_si = 0; e_wp = 1; e_busy = 0;
  endtask

  always @(posedge clk) begin
    if (rst) model_reset();
    else begin
      bit c, k, hd, up, dn, ab;
      int nx;
      c = h2[0]; k = h2[1]; hd = h2[3];
      up = k && !prev_clk_lvl; dn = !k && prev_clk_lvl;
      nx = mode; ab = 0;
      if (mode != 0 && c) begin nx = 0; ab = !hd; end
      else if (mode == 0) begin if (!c) nx = 1; end
      else if (mode == 1) begin if (!hd) nx = k ? 2 : 3; end
      else if (mode == 2) begin if (hd) nx = 1; else if (!k) nx = 3; end
      else if (mode == 3) begin if (hd) nx = k ? 4 : 1; end
      else begin if (!hd) nx = 3; else if (!k) nx = 1; end
      e_oe = (nx == 1 || nx == 2);
      e_hold = (nx == 3 || nx == 4);
      e_rise = up && e_oe;
      e_fall = dn && e_oe;
      e_abort = ab;
      if (wel_clr || ab) e_wel = 0; else if (wel_set) e_wel = 1;
      e_si = h2[2]; e_wp = h2[4]; e_busy = h2[5];
      mode = nx;
      prev_clk_lvl = k;
      h2 = h1;
      h1 = '{cs_n, sck, si, hold_n, wp_n, busy};
    end
  end

  task automatic cmp(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      cmp("R4 so_oe", so_oe, e_oe);
      cmp("R2 R3 hold_active", hold_active, e_hold);
      cmp("R5 shift_rise", shift_rise, e_rise);
      cmp("R5 shift_fall", shift_fall, e_fall);
      cmp("R7 abort_pulse", abort_pulse, e_abort);
      cmp("R8 wel", wel, e_wel);
      cmp("R9 si_bit", si_bit, e_si);
      cmp("R6 wp_n_o", wp_n_o, e_wp);
      cmp("R6 busy_o", busy_o, e_busy);
      if (abort_pulse) abort_seen++;
      if (hold_active && (shift_rise || shift_fall)) shifts_in_hold++;
    end
    if (sck_run) begin
      sck_cnt++;
      if (sck_cnt == 4) begin
        sck_cnt = 0;
        sck = ~sck;
        if (!sck) si = ~si ^ cycles[3];
      end
    end
  end

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_lvl(input bit v);
    @(negedge clk);
    while (sck !== v || sck_cnt != 1) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    wait_clk(200000 - 10);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    wait_clk(3);
    cmp("R1 reset so_oe", so_oe, 0);
    cmp("R1 reset hold_active", hold_active, 0);
    cmp("R1 reset wel", wel, 0);
    cmp("R1 reset abort_pulse", abort_pulse, 0);
    cmp("R1 reset shift_rise", shift_rise, 0);
    rst = 0;
    wait_clk(4);
    // select and shift
    cs_n = 0;
    sck_run = 1;
    wait_clk(40);
    // R8 set then clear with priority
    wel_set = 1; wait_clk(1); wel_set = 0; wait_clk(2);
    cmp("R8 wel set", wel, 1);
    wel_set = 1; wel_clr = 1; wait_clk(1); wel_set = 0; wel_clr = 0; wait_clk(2);
    cmp("R8 clear wins", wel, 0);
    // R2 pause asserted with sck low: immediate
    wait_lvl(0); hold_n = 0; wait_clk(20);
    // R6 wp and busy move during pause
    wp_n = 0; busy = 1; wait_clk(6);
    cmp("R6 wp in hold", wp_n_o, 0);
    cmp("R6 busy in hold", busy_o, 1);
    // R3 release with sck high: deferred
    wait_lvl(1); hold_n = 1; wait_clk(16);
    // R2 pause asserted with sck high: deferred
    wait_lvl(1); hold_n = 0; wait_clk(20);
    // R3 release with sck low: immediate
    wait_lvl(0); hold_n = 1; wait_clk(16);
    // R2 pending pause cancelled
    wait_lvl(1); hold_n = 0; wait_clk(1); hold_n = 1; wait_clk(16);
    wp_n = 1; busy = 0;
    // R7 deselect while paused: abort and latch clear
    wel_set = 1; wait_clk(1); wel_set = 0;
    wait_lvl(0); hold_n = 0; wait_clk(10);
    sck_run = 0;
    cs_n = 1; wait_clk(6);
    cmp("R7 abort issued", abort_seen == 1, 1);
    cmp("R7 wel cleared", wel, 0);
    hold_n = 1; wait_clk(6);
    // R7 deselect without pause: no abort
    cs_n = 0; sck_run = 1; wel_set = 1; wait_clk(1); wel_set = 0; wait_clk(30);
    sck_run = 0; cs_n = 1; wait_clk(8);
    cmp("R7 no abort without hold", abort_seen == 1, 1);
    cmp("R7 wel kept", wel, 1);
    cmp("R4 so_oe off when deselected", so_oe, 0);
    cmp("R5 no shift while paused", shifts_in_hold == 0, 1);
    finish_run();
  end
endmodule